// File: doc/BRIEF.md
# Transmit Descriptor Queue Pointer

This block sits at the front of a network transmit DMA engine. Software places the start address of a ring of transmit descriptors, together with a queue-off flag, into one 32-bit register through a plain write/read port. A single-cycle start pulse then hands the ring to hardware. From that point the block keeps a current-descriptor pointer and walks the ring by issuing descriptor reads to a memory read port. Each descriptor is two 32-bit words: an address word and a status word. When the datapath is 64 bits wide, a descriptor is fetched with one 8-byte read. When it is 32 bits wide, the two words are fetched with two separate 4-byte reads.

After each complete descriptor, the pointer moves forward by 8 bytes. If the fetched status word carries the ring-end flag, the pointer jumps back to the base address instead. While transmit runs, the register is frozen against writes, and reading it shows where the hardware currently is in the ring. A stop pulse abandons any fetch in progress, reloads the pointer from the base address and opens the register to software again.

Top module: `txq_ptr_unit`

## Requirements
- R1: After reset the register reads 0 and no read request is raised.
- R2: While transmit is stopped, a write stores bits 31:2 as the ring base and bit 0 as the queue-off flag (1 = off). Bit 1 always reads 0, and a read returns the stored value.
- R3: A write in the same cycle as the start pulse, or in any cycle while transmit runs, changes neither the base nor the flag.
- R4: A write in the same cycle as the stop pulse is ignored. A write one cycle after the stop pulse is taken.
- R5: The first descriptor read after start goes to the base address. While running, a register read returns the live pointer, which is always base plus a multiple of 8 inside the ring.
- R6: With the 64-bit datapath, each descriptor costs one request of size code 3 (8 bytes) at the pointer, and the status word is response bits 63:32.
- R7: With the 32-bit datapath, each descriptor costs two requests of size code 2 (4 bytes): first at the pointer, then at pointer+4. The status word is bits 31:0 of the second response.
- R8: After the last response of a descriptor whose status bit 30 is 0, the pointer grows by 8. All other status bits have no effect.
- R9: After the last response of a descriptor whose status bit 30 is 1, the pointer returns to the base address.
- R10: While the queue-off flag is 1, no read request is raised, even with transmit started.
- R11: A request keeps valid and address steady until ready is seen. No new request is raised while a response is still owed.
- R12: A stop pulse drops the fetch in progress and reloads the pointer from the base. This holds even when a final response arrives in the stop cycle, so the next start fetches from the base first.
- R13: With the 64-bit datapath, address bit 2 of a write is stored as 0. With the 32-bit datapath it is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | ADDR_W | Write data: base in 31:2, queue-off flag in 0 |
| reg_rdata | output | ADDR_W | Stored base (stopped) or live pointer (running), flag in bit 0 |
| tx_start | input | 1 | One-cycle pulse that starts transmit |
| tx_stop | input | 1 | One-cycle pulse that stops transmit |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Byte address of the read |
| rd_req_size | output | 2 | log2 of the byte count: 2 or 3 |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DP_W | Read data |

## Verification
Two collisions are provoked on purpose. The first is a register write presented in the very cycle of the start pulse; after a later stop, the read-back must still show the old base. The second is a stop pulse raised in the same cycle as a final descriptor response; the pointer must come back to the base rather than advance, which is judged by restarting and checking that the first request address is the base. Both datapath widths see identical stimulus side by side, and ring sizes of one to four descriptors at several bases, including one near the top of the address space, are swept. Request addresses are compared with base plus 8 times the descriptor index modulo the ring size.

// File: rtl/txq_pkg.sv
// Package: shared types and constants for the transmit descriptor
// queue pointer. Assumes descriptors of two 32-bit words.
package txq_pkg;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_REQ0  = 3'd1,
        FS_WAIT0 = 3'd2,
        FS_REQ1  = 3'd3,
        FS_WAIT1 = 3'd4
    } fetch_state_e;

    localparam logic [1:0] SZ_4B = 2'd2;
    localparam logic [1:0] SZ_8B = 2'd3;
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/txq_base_reg.sv
// Module: holds the software-written ring base and queue-off flag, plus
// the transmit lock. Writes are taken only while unlocked and not in a
// start cycle. The lock sets on start and clears on stop; stop wins.
// Assumes start and stop are single-cycle pulses.
module txq_base_reg #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DP_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              tx_start,
    input  logic              tx_stop,
    output logic [ADDR_W-1:0] base_o,
    output logic              qdis_o,
    output logic              locked_o
);
    localparam int unsigned ALIGN_LSB = (DP_W == 64) ? 3 : 2;
    localparam logic [ADDR_W-1:0] ADDR_MASK = ~ADDR_W'((1 << ALIGN_LSB) - 1);

    logic [ADDR_W-1:0] base_q;
    logic              qdis_q;
    logic              locked_q;
    logic              wr_take;

    assign wr_take = wr_en && !locked_q && !tx_start;

    // Capture base and flag on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            qdis_q <= 1'b0;
        end else if (wr_take) begin
            base_q <= wr_data & ADDR_MASK;
            qdis_q <= wr_data[0];
        end
    end

    // Track whether transmit owns the ring.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked_q <= 1'b0;
        else if (tx_stop)  locked_q <= 1'b0;
        else if (tx_start) locked_q <= 1'b1;
    end

    assign base_o   = base_q;
    assign qdis_o   = qdis_q;
    assign locked_o = locked_q;

    wire unused_wbits = &{1'b0, wr_data[ALIGN_LSB-1:1]};

    AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> ($stable(base_q) && $stable(qdis_q))); // R3
    AST_START_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !tx_stop) |=> locked_q); // R3
    AST_STOP_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop |=> !locked_q); // R4
endmodule

// File: rtl/txq_fetch_seq.sv
// Module: descriptor fetch sequencer and current-descriptor pointer.
// One request is outstanding at most. With a 64-bit datapath a descriptor
// is one 8-byte read; with 32 bits it is two 4-byte reads. On the final
// response the pointer steps 8 bytes, or returns to base when the status
// wrap bit is set. Abort or not running parks it and reloads from base.
module txq_fetch_seq
    import txq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DP_W     = 64,
    parameter int unsigned WRAP_BIT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              abort,
    input  logic              qdis,
    input  logic [ADDR_W-1:0] base,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        req_size,
    input  logic              rsp_valid,
    input  logic [DP_W-1:0]   rsp_data,
    output logic [ADDR_W-1:0] ptr_o
);
    fetch_state_e      state_q, state_d;
    fetch_state_e      fin_state;
    logic [ADDR_W-1:0] ptr_q;
    logic [31:0]       status_w;
    logic              desc_done;
    logic              split_rd;

    // Pick the status lane and the final wait state for the datapath width.
    generate
        if (DP_W == 64) begin : g_dp64
            assign status_w  = rsp_data[DP_W-1 -: 32];
            assign fin_state = FS_WAIT0;
            assign split_rd  = 1'b0;
            wire unused_low = &{1'b0, rsp_data[DP_W-33:0]};
        end else begin : g_dp32
            assign status_w  = rsp_data[31:0];
            assign fin_state = FS_WAIT1;
            assign split_rd  = 1'b1;
        end
    endgenerate

    assign desc_done = rsp_valid && (state_q == fin_state);

    // Next-state logic for the fetch walk.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (!qdis)     state_d = FS_REQ0;
            FS_REQ0:  if (req_ready) state_d = FS_WAIT0;
            FS_WAIT0: if (rsp_valid) state_d = split_rd ? FS_REQ1 : FS_REQ0;
            FS_REQ1:  if (req_ready) state_d = FS_WAIT1;
            FS_WAIT1: if (rsp_valid) state_d = FS_REQ0;
            default:                 state_d = FS_IDLE;
        endcase
    end

    // State and pointer registers; abort or idle reloads from base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            ptr_q   <= '0;
        end else if (abort || !running) begin
            state_q <= FS_IDLE;
            ptr_q   <= base;
        end else begin
            state_q <= state_d;
            if (desc_done)
                ptr_q <= status_w[WRAP_BIT] ? base : ptr_q + ADDR_W'(DESC_BYTES);
        end
    end

    // Drive the request port from the state.
    always_comb begin
        req_valid = ((state_q == FS_REQ0) || (state_q == FS_REQ1)) && !abort;
        req_addr  = (state_q == FS_REQ1) ? ptr_q + ADDR_W'(WORD_BYTES) : ptr_q;
        req_size  = split_rd ? SZ_4B : SZ_8B;
    end

    assign ptr_o = ptr_q;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !abort && desc_done && !status_w[WRAP_BIT])
        |=> (ptr_q == $past(ptr_q) + ADDR_W'(DESC_BYTES))); // R8
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !abort && desc_done && status_w[WRAP_BIT])
        |=> (ptr_q == $past(base))); // R9
    AST_ABORT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (ptr_q == $past(base))); // R12
endmodule

// File: rtl/txq_ptr_unit.sv
// Module: top of the transmit descriptor queue pointer. Joins the base
// register and the fetch sequencer and muxes the read-back: stored base
// while stopped, live pointer while running. Assumes one clock domain and
// that the memory answers every accepted request with one response.
module txq_ptr_unit
    import txq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DP_W     = 64,
    parameter int unsigned WRAP_BIT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              tx_start,
    input  logic              tx_stop,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [1:0]        rd_req_size,
    input  logic              rd_rsp_valid,
    input  logic [DP_W-1:0]   rd_rsp_data
);
    localparam int unsigned ALIGN_LSB = (DP_W == 64) ? 3 : 2;

    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] ptr_w;
    logic              qdis_w;
    logic              locked_w;

    txq_base_reg #(.ADDR_W(ADDR_W), .DP_W(DP_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_data  (reg_wdata),
        .tx_start (tx_start),
        .tx_stop  (tx_stop),
        .base_o   (base_w),
        .qdis_o   (qdis_w),
        .locked_o (locked_w)
    );

    txq_fetch_seq #(.ADDR_W(ADDR_W), .DP_W(DP_W), .WRAP_BIT(WRAP_BIT)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (locked_w),
        .abort     (tx_stop),
        .qdis      (qdis_w),
        .base      (base_w),
        .req_valid (rd_req_valid),
        .req_ready (rd_req_ready),
        .req_addr  (rd_req_addr),
        .req_size  (rd_req_size),
        .rsp_valid (rd_rsp_valid),
        .rsp_data  (rd_rsp_data),
        .ptr_o     (ptr_w)
    );

    // Read-back: stored base while stopped, live pointer while running.
    always_comb begin
        reg_rdata      = locked_w ? ptr_w : base_w;
        reg_rdata[1:0] = {1'b0, qdis_w};
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        qdis_w |-> !rd_req_valid); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready)
        |=> (tx_stop || (rd_req_valid && $stable(rd_req_addr)))); // R11
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr[ALIGN_LSB-1:0] == '0)); // R13
endmodule

// File: tb/txq_ptr_unit_tb.sv
// Bench: runs a 64-bit and a 32-bit instance on shared stimulus, each
// with its own memory model, and sweeps ring sizes and bases.
module txq_ptr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        tx_start = 1'b0;
    logic        tx_stop = 1'b0;
    logic        log_clr = 1'b0;
    logic [31:0] wrap_addr = '0;

    logic        rqv_a, rdy_a, rsv_a, rqv_b, rdy_b, rsv_b;
    logic [31:0] rqa_a, rqa_b, rd_a, rd_b;
    logic [1:0]  rqs_a, rqs_b;
    logic [63:0] rsd_a;
    logic [31:0] rsd_b;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    txq_ptr_unit #(.ADDR_W(32), .DP_W(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(rd_a), .tx_start(tx_start), .tx_stop(tx_stop),
        .rd_req_valid(rqv_a), .rd_req_ready(rdy_a), .rd_req_addr(rqa_a),
        .rd_req_size(rqs_a), .rd_rsp_valid(rsv_a), .rd_rsp_data(rsd_a));

    txq_ptr_unit #(.ADDR_W(32), .DP_W(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(rd_b), .tx_start(tx_start), .tx_stop(tx_stop),
        .rd_req_valid(rqv_b), .rd_req_ready(rdy_b), .rd_req_addr(rqa_b),
        .rd_req_size(rqs_b), .rd_rsp_valid(rsv_b), .rd_rsp_data(rsd_b));

    // Status word of the descriptor at a given address: only bit 30 decides.
    function automatic logic [31:0] status_of(input logic [31:0] d);
        return (d == wrap_addr) ? 32'h4000_0000 : 32'hBFFF_FFFF;
    endfunction

    // Memory models: log requests, count protocol errors, answer after 3 cycles.
    logic [31:0] log_a [0:63];
    logic [31:0] log_b [0:63];
    int n_a, n_b, ovl, szerr, lat_a, lat_b, rc;
    logic pend_a, pend_b;
    logic [31:0] pa_a, pa_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            n_a <= 0; n_b <= 0; ovl <= 0; szerr <= 0; rc <= 0;
            pend_a <= 1'b0; pend_b <= 1'b0; rsv_a <= 1'b0; rsv_b <= 1'b0;
            rdy_a <= 1'b0; rdy_b <= 1'b0; lat_a <= 0; lat_b <= 0;
            rsd_a <= '0; rsd_b <= '0; pa_a <= '0; pa_b <= '0;
        end else begin
            rc <= rc + 1;
            rdy_a <= (rc % 3) != 2;
            rdy_b <= (rc % 4) != 1;
            rsv_a <= 1'b0;
            rsv_b <= 1'b0;
            if (rqv_a && rdy_a) begin
                if (pend_a) ovl <= ovl + 1;
                if (rqs_a != 2'd3) szerr <= szerr + 1;
                pend_a <= 1'b1; pa_a <= rqa_a; lat_a <= 2;
                if (n_a < 64) begin log_a[n_a] <= rqa_a; n_a <= n_a + 1; end
            end else if (pend_a) begin
                if (lat_a == 0) begin
                    rsv_a <= 1'b1; pend_a <= 1'b0;
                    rsd_a <= {status_of(pa_a), pa_a ^ 32'h5A5A_0000};
                end else lat_a <= lat_a - 1;
            end
            if (rqv_b && rdy_b) begin
                if (pend_b) ovl <= ovl + 1;
                if (rqs_b != 2'd2) szerr <= szerr + 1;
                pend_b <= 1'b1; pa_b <= rqa_b; lat_b <= 2;
                if (n_b < 64) begin log_b[n_b] <= rqa_b; n_b <= n_b + 1; end
            end else if (pend_b) begin
                if (lat_b == 0) begin
                    rsv_b <= 1'b1; pend_b <= 1'b0;
                    rsd_b <= pa_b[2] ? status_of(pa_b - 32'd4) : pa_b;
                end else lat_b <= lat_b - 1;
            end
            if (log_clr) begin n_a <= 0; n_b <= 0; end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000 && !done) begin
            n_chk = n_chk + 1; n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic pulse_start(input logic [31:0] clash);
        @(negedge clk); tx_start = 1'b1; reg_we = 1'b1; reg_wdata = clash;
        @(negedge clk); tx_start = 1'b0; reg_we = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); tx_stop = 1'b1;
        @(negedge clk); tx_stop = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic clr_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic run_ring(input logic [31:0] base, input int nd);
        int m;
        logic [31:0] live;
        m = 2 * nd + 1;
        wr(base);
        check(rd_a == base && rd_b == base, "R2 readback", rd_a, base);
        wrap_addr = base + 32'(8 * (nd - 1));
        clr_log();
        pulse_start(base ^ 32'h0000_0F00);
        for (int t = 0; t < 600 && !(n_a >= m && n_b >= 2 * m); t++) @(negedge clk);
        check(n_a >= m && n_b >= 2 * m, "R5 fetch progress", 32'(n_b), 32'(2 * m));
        live = rd_a - base;
        check(live[2:0] == 3'b000 && live < 32'(8 * nd), "R5 live pointer", rd_a, base);
        wr(32'h0BAD_0000);
        pulse_stop();
        check(rd_a == base && rd_b == base, "R3 base kept after locked writes", rd_a, base);
        for (int k = 0; k < m; k++) begin
            logic [31:0] e;
            e = base + 32'(8 * (k % nd));
            check(log_a[k] == e, "R8 R9 64-bit fetch address", log_a[k], e);
            check(log_b[2 * k] == e, "R7 32-bit first word", log_b[2 * k], e);
            check(log_b[2 * k + 1] == e + 32'd4, "R7 32-bit second word", log_b[2 * k + 1], e + 32'd4);
        end
        check(log_a[0] == base, "R5 first fetch at base", log_a[0], base);
    endtask

    initial begin
        logic [31:0] bases [0:2];
        bases[0] = 32'h0000_1000;
        bases[1] = 32'h0012_3440;
        bases[2] = 32'hFFFF_FFE0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_a == 32'd0 && rd_b == 32'd0, "R1 reset readback", rd_a, 32'd0);
        check(!rqv_a && !rqv_b, "R1 no request after reset", {30'd0, rqv_a, rqv_b}, 32'd0);

        // R13 and R2: bit 2 handling per width, bit 1 always reads 0.
        wr(32'h0000_2004);
        check(rd_a == 32'h0000_2000, "R13 64-bit drops bit 2", rd_a, 32'h0000_2000);
        check(rd_b == 32'h0000_2004, "R13 32-bit keeps bit 2", rd_b, 32'h0000_2004);
        wr(32'h0000_3007);
        check(rd_a == 32'h0000_3001, "R2 flag and bit 1 (64)", rd_a, 32'h0000_3001);
        check(rd_b == 32'h0000_3005, "R2 flag and bit 1 (32)", rd_b, 32'h0000_3005);

        // R10: queue off means no requests while started.
        wr(32'h0000_4001);
        clr_log();
        pulse_start(32'h0000_4001);
        repeat (20) @(negedge clk);
        check(n_a == 0 && n_b == 0, "R10 no fetch while off", 32'(n_a + n_b), 32'd0);

        // R4: write in stop cycle ignored, write one cycle later taken.
        @(negedge clk); tx_stop = 1'b1; reg_we = 1'b1; reg_wdata = 32'h0000_5000;
        @(negedge clk); tx_stop = 1'b0;
        check(rd_a == 32'h0000_4001, "R4 stop-cycle write ignored", rd_a, 32'h0000_4001);
        reg_wdata = 32'h0000_6000;
        @(negedge clk); reg_we = 1'b0;
        check(rd_a == 32'h0000_6000 && rd_b == 32'h0000_6000, "R4 post-stop write taken", rd_a, 32'h0000_6000);

        // Sweep ring sizes and bases: R3 R5 R6 R7 R8 R9.
        for (int b = 0; b < 3; b++)
            for (int nd = 1; nd <= 4; nd++)
                run_ring(bases[b], nd);

        // R12: stop in the same cycle as a final 64-bit response.
        wr(32'h0000_8000);
        wrap_addr = 32'h0000_8010;
        clr_log();
        pulse_start(32'h0000_8000);
        for (int t = 0; t < 200 && n_a < 2; t++) @(negedge clk);
        for (int t = 0; t < 50 && !rsv_a; t++) @(negedge clk);
        check(rsv_a, "R12 response seen for collision", {31'd0, rsv_a}, 32'd1);
        tx_stop = 1'b1;
        @(negedge clk); tx_stop = 1'b0;
        repeat (6) @(negedge clk);
        clr_log();
        pulse_start(32'h0000_8000);
        for (int t = 0; t < 200 && !(n_a >= 1 && n_b >= 1); t++) @(negedge clk);
        check(log_a[0] == 32'h0000_8000, "R12 restart from base (64)", log_a[0], 32'h0000_8000);
        check(log_b[0] == 32'h0000_8000, "R12 restart from base (32)", log_b[0], 32'h0000_8000);
        pulse_stop();

        check(ovl == 0, "R11 one outstanding request", 32'(ovl), 32'd0);
        check(szerr == 0, "R6 R7 size codes", 32'(szerr), 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule